// File: doc/BRIEF.md
# Autocorrelation Packet Start Qualifier

This block decides when a received packet has begun. On every sample it receives two inputs for each of two RF chains: a normalized autocorrelation value and a sample magnitude. Both arrive precomputed. A chain counts a sample as qualifying only when both values sit strictly above their programmed thresholds. The chain declares a detection once it has seen a programmed number of qualifying samples in a row. An optional external detect line can also start a detection, if its enable is set.

Each detection produces a one-clock output pulse with a source vector that shows which inputs fired, and it adds one to a 32-bit statistics counter. It also starts a holdoff window, counted in units of 16 clocks, during which no new detection is possible. The configuration arrives as plain input ports. The synchronous state-clear input returns the detection logic to idle and does not touch the counter. A separate clear input zeroes the counter.

Top module: `acpd_qualifier`

## Requirements
- R1: A sample qualifies on a chain only when its correlation is strictly greater than `thr_corr` and its magnitude is strictly greater than `thr_mag`. A value equal to its threshold does not qualify.
- R2: A chain fires on the valid sample that completes `min_run` consecutive qualifying samples. A `min_run` of 0 behaves like 1.
- R3: A valid sample that does not qualify sets that chain's run to zero. A clock with `smp_vld` low neither advances nor resets any run.
- R4: While `en_a` (or `en_b`) is low, that chain never fires, whatever its inputs are.
- R5: With `ext_en` high, `ext_det` high fires a detection at that clock edge. With `ext_en` low, `ext_det` has no effect.
- R6: A detection is registered. `det_pulse` is high for the clock that follows the firing sample. `det_src` bit 0 marks chain A, bit 1 marks chain B and bit 4 marks the external input. Bits 3:2 are always 0, and the whole vector is 0 when there is no pulse.
- R7: After a detection, the next `holdoff_units`*16 clock edges cannot fire. Each detection sets both runs to zero, and the runs stay at zero through the holdoff.
- R8: `det_count` adds one for each pulse. `clr_stats` sets it to zero and wins over a simultaneous increment.
- R9: `clr_state` clears both runs and the holdoff, and it blocks any detection on that edge. It leaves `det_count` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_state | input | 1 | Synchronous clear of detection state |
| clr_stats | input | 1 | Synchronous clear of the event counter |
| smp_vld | input | 1 | A new sample is present this clock |
| corr_a | input | 8 | Chain A normalized correlation, all bits fractional |
| mag_a | input | 14 | Chain A magnitude, 3 fractional bits |
| corr_b | input | 8 | Chain B normalized correlation |
| mag_b | input | 14 | Chain B magnitude |
| thr_corr | input | 8 | Correlation threshold |
| thr_mag | input | 14 | Magnitude threshold |
| min_run | input | 4 | Required consecutive qualifying samples |
| holdoff_units | input | 6 | Holdoff length in 16-clock units |
| en_a | input | 1 | Chain A detection enable |
| en_b | input | 1 | Chain B detection enable |
| ext_en | input | 1 | External detect enable |
| ext_det | input | 1 | External detect input |
| det_pulse | output | 1 | One-clock detection pulse |
| det_src | output | 5 | Sources that fired |
| det_count | output | 32 | Detection event count |

## Verification
A run counter that fails to clear shows up as a pulse arriving one or more samples too early, within the next `min_run` valid samples. A run counter that clears when it should hold shows up as a pulse arriving late. If the holdoff counter is loaded or decremented wrongly, the second external detection arrives on the wrong clock. Driving `ext_det` continuously exposes this within 17 clocks when the holdoff is one unit. Source-bit mixups and counter faults are visible on the pulse itself, in the same cycle.

// File: rtl/acpd_qualifier.sv
module acpd_qualifier #(
  parameter int CORR_W     = 8,
  parameter int MAG_W      = 14,
  parameter int RUN_W      = 4,
  parameter int HOLD_W     = 6,
  parameter int HOLD_SHIFT = 4,
  parameter int CNT_W      = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_state,
  input  logic              clr_stats,
  input  logic              smp_vld,
  input  logic [CORR_W-1:0] corr_a,
  input  logic [MAG_W-1:0]  mag_a,
  input  logic [CORR_W-1:0] corr_b,
  input  logic [MAG_W-1:0]  mag_b,
  input  logic [CORR_W-1:0] thr_corr,
  input  logic [MAG_W-1:0]  thr_mag,
  input  logic [RUN_W-1:0]  min_run,
  input  logic [HOLD_W-1:0] holdoff_units,
  input  logic              en_a,
  input  logic              en_b,
  input  logic              ext_en,
  input  logic              ext_det,
  output logic              det_pulse,
  output logic [4:0]        det_src,
  output logic [CNT_W-1:0]  det_count
);

  localparam int HCNT_W = HOLD_W + HOLD_SHIFT;

  logic [HCNT_W-1:0] hold_cnt;
  logic [RUN_W-1:0]  run_a, run_b, goal;
  logic [RUN_W:0]    nxt_a, nxt_b;
  logic              holding, ok, hit_a, hit_b;
  logic              fire_a, fire_b, fire_x, fire_any;

  assign holding  = |hold_cnt;
  assign ok       = ~clr_state & ~holding;
  assign goal     = (min_run == '0) ? RUN_W'(1) : min_run;

  assign hit_a    = smp_vld & en_a & (corr_a > thr_corr) & (mag_a > thr_mag);
  assign hit_b    = smp_vld & en_b & (corr_b > thr_corr) & (mag_b > thr_mag);
  assign nxt_a    = {1'b0, run_a} + (RUN_W+1)'(1);
  assign nxt_b    = {1'b0, run_b} + (RUN_W+1)'(1);

  assign fire_a   = ok & hit_a & (nxt_a >= {1'b0, goal});
  assign fire_b   = ok & hit_b & (nxt_b >= {1'b0, goal});
  assign fire_x   = ok & ext_en & ext_det;
  assign fire_any = fire_a | fire_b | fire_x;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_a <= '0;
      run_b <= '0;
    end else if (clr_state || holding || fire_any) begin
      run_a <= '0;
      run_b <= '0;
    end else if (smp_vld) begin
      run_a <= hit_a ? nxt_a[RUN_W-1:0] : '0;
      run_b <= hit_b ? nxt_b[RUN_W-1:0] : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      hold_cnt <= '0;
    else if (clr_state)
      hold_cnt <= '0;
    else if (fire_any)
      hold_cnt <= {holdoff_units, {HOLD_SHIFT{1'b0}}};
    else if (holding)
      hold_cnt <= hold_cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      det_pulse <= 1'b0;
      det_src   <= '0;
    end else begin
      det_pulse <= fire_any;
      det_src   <= {fire_x, 2'b00, fire_b, fire_a};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      det_count <= '0;
    else if (clr_stats)
      det_count <= '0;
    else if (fire_any)
      det_count <= det_count + 1'b1;
  end

endmodule

// File: rtl/acpd_qualifier_chk.sv
module acpd_qualifier_chk #(
  parameter int HOLD_W = 6,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr_state,
  input logic              clr_stats,
  input logic [HOLD_W-1:0] holdoff_units,
  input logic              en_a,
  input logic              en_b,
  input logic              ext_en,
  input logic              ext_det,
  input logic              det_pulse,
  input logic [4:0]        det_src,
  input logic [CNT_W-1:0]  det_count
);

  p_src_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (det_pulse == (det_src != 5'd0)) && (det_src[3:2] == 2'b00));

  p_ant_a_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    det_src[0] |-> $past(en_a));

  p_ant_b_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    det_src[1] |-> $past(en_b));

  p_ext_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    det_src[4] |-> ($past(ext_en) && $past(ext_det)));

  p_holdoff_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (det_pulse && ($past(holdoff_units) != '0)) |=> !det_pulse);

  p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_stats |=> (det_count == $past(det_count) + CNT_W'(det_pulse)));

  p_stats_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stats |=> (det_count == '0));

  p_state_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_state |=> !det_pulse);

endmodule

bind acpd_qualifier acpd_qualifier_chk #(.HOLD_W(HOLD_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_state(clr_state), .clr_stats(clr_stats),
  .holdoff_units(holdoff_units), .en_a(en_a), .en_b(en_b), .ext_en(ext_en),
  .ext_det(ext_det), .det_pulse(det_pulse), .det_src(det_src), .det_count(det_count)
);

// File: tb/acpd_qualifier_tb_top.sv
module acpd_qualifier_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr_state = 1'b0, clr_stats = 1'b0, smp_vld = 1'b0;
  logic [7:0]  corr_a = '0, corr_b = '0, thr_corr = 8'h80;
  logic [13:0] mag_a = '0, mag_b = '0, thr_mag = 14'h0100;
  logic [3:0]  min_run = 4'd3;
  logic [5:0]  holdoff_units = '0;
  logic        en_a = 1'b1, en_b = 1'b0, ext_en = 1'b0, ext_det = 1'b0;
  logic        det_pulse;
  logic [4:0]  det_src;
  logic [31:0] det_count;

  int nchk = 0, nfail = 0;
  logic [31:0] c0;

  localparam logic [7:0]  HC = 8'hA0, LC = 8'h10;
  localparam logic [13:0] HM = 14'h0200, LM = 14'h0010;

  localparam logic [22:0] VEC [12] = '{
    {HC,    HM,       1'b0},
    {HC,    HM,       1'b0},
    {HC,    HM,       1'b1},
    {HC,    HM,       1'b0},
    {8'h80, HM,       1'b0},
    {HC,    HM,       1'b0},
    {HC,    HM,       1'b0},
    {HC,    14'h0100, 1'b0},
    {HC,    HM,       1'b0},
    {HC,    HM,       1'b0},
    {HC,    HM,       1'b1},
    {LC,    LM,       1'b0}
  };

  always #2 clk = ~clk;

  acpd_qualifier dut_i (
    .clk(clk), .rst_n(rst_n), .clr_state(clr_state), .clr_stats(clr_stats),
    .smp_vld(smp_vld), .corr_a(corr_a), .mag_a(mag_a), .corr_b(corr_b), .mag_b(mag_b),
    .thr_corr(thr_corr), .thr_mag(thr_mag), .min_run(min_run),
    .holdoff_units(holdoff_units), .en_a(en_a), .en_b(en_b), .ext_en(ext_en),
    .ext_det(ext_det), .det_pulse(det_pulse), .det_src(det_src), .det_count(det_count)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic put(input logic v, input logic [7:0] ca, input logic [13:0] ma,
                     input logic [7:0] cb, input logic [13:0] mb, input logic xd);
    smp_vld = v; corr_a = ca; mag_a = ma; corr_b = cb; mag_b = mb; ext_det = xd;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) put(1'b0, LC, LM, LC, LM, 1'b0);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R6 reset pulse", 32'(det_pulse), 0);
    chk("R6 reset src", 32'(det_src), 0);
    chk("R8 reset count", det_count, 0);

    for (int i = 0; i < 12; i++) begin
      put(1'b1, VEC[i][22:15], VEC[i][14:1], LC, LM, 1'b0);
      chk($sformatf("R1/R2 vector %0d", i), 32'(det_pulse), 32'(VEC[i][0]));
    end
    chk("R8 count after table", det_count, 2);

    // R3: clocks without a valid sample keep the run
    put(1'b1, HC, HM, LC, LM, 1'b0);
    put(1'b0, LC, LM, LC, LM, 1'b0);
    put(1'b0, LC, LM, LC, LM, 1'b0);
    put(1'b1, HC, HM, LC, LM, 1'b0);
    chk("R3 gap no early fire", 32'(det_pulse), 0);
    put(1'b0, LC, LM, LC, LM, 1'b0);
    put(1'b1, HC, HM, LC, LM, 1'b0);
    chk("R3 gap run kept", 32'(det_pulse), 1);
    chk("R6 src chain A", 32'(det_src), 32'h01);

    // R2: zero run behaves as one
    min_run = 4'd0;
    put(1'b1, HC, HM, LC, LM, 1'b0);
    chk("R2 min_run zero", 32'(det_pulse), 1);
    min_run = 4'd2;
    idle(2);

    // R6: both chains, then B alone
    en_b = 1'b1;
    put(1'b1, HC, HM, HC, HM, 1'b0);
    chk("R6 both first", 32'(det_pulse), 0);
    put(1'b1, HC, HM, HC, HM, 1'b0);
    chk("R6 both src", 32'(det_src), 32'h03);
    put(1'b1, LC, LM, HC, HM, 1'b0);
    put(1'b1, LC, LM, HC, HM, 1'b0);
    chk("R6 src chain B", 32'(det_src), 32'h02);

    // R4: disabled chain A
    en_a = 1'b0;
    c0 = det_count;
    for (int i = 0; i < 4; i++) begin
      put(1'b1, HC, HM, LC, LM, 1'b0);
      chk("R4 chain A disabled", 32'(det_pulse), 0);
    end
    chk("R4 count unchanged", det_count, c0);
    en_a = 1'b1;
    en_b = 1'b0;
    idle(1);

    // R5: external input
    ext_en = 1'b0;
    for (int i = 0; i < 3; i++) begin
      put(1'b0, LC, LM, LC, LM, 1'b1);
      chk("R5 ext ignored", 32'(det_pulse), 0);
    end
    ext_en = 1'b1;
    put(1'b0, LC, LM, LC, LM, 1'b1);
    chk("R5 ext fires", 32'(det_src), 32'h10);
    put(1'b0, LC, LM, LC, LM, 1'b0);
    chk("R5 ext released", 32'(det_pulse), 0);

    // R7: holdoff of one unit with ext held
    holdoff_units = 6'd1;
    c0 = det_count;
    put(1'b0, LC, LM, LC, LM, 1'b1);
    chk("R7 first ext pulse", 32'(det_pulse), 1);
    for (int i = 0; i < 16; i++) begin
      put(1'b0, LC, LM, LC, LM, 1'b1);
      chk("R7 blocked during holdoff", 32'(det_pulse), 0);
    end
    put(1'b0, LC, LM, LC, LM, 1'b1);
    chk("R7 fires after holdoff", 32'(det_pulse), 1);
    chk("R8 count two pulses", det_count, c0 + 2);
    ext_en = 1'b0;
    idle(20);

    // R7: runs held at zero during holdoff
    for (int i = 0; i < 22; i++) begin
      put(1'b1, HC, HM, LC, LM, 1'b0);
      chk($sformatf("R7 run restart sample %0d", i), 32'(det_pulse),
          32'((i == 1) || (i == 19)));
    end
    idle(20);

    // R9: clr_state
    holdoff_units = 6'd0;
    min_run = 4'd3;
    c0 = det_count;
    put(1'b1, HC, HM, LC, LM, 1'b0);
    put(1'b1, HC, HM, LC, LM, 1'b0);
    clr_state = 1'b1;
    put(1'b1, HC, HM, LC, LM, 1'b0);
    chk("R9 clear blocks fire", 32'(det_pulse), 0);
    clr_state = 1'b0;
    put(1'b1, HC, HM, LC, LM, 1'b0);
    put(1'b1, HC, HM, LC, LM, 1'b0);
    chk("R9 run was cleared", 32'(det_pulse), 0);
    put(1'b1, HC, HM, LC, LM, 1'b0);
    chk("R9 fresh run fires", 32'(det_pulse), 1);
    chk("R9 count kept", det_count, c0 + 1);

    holdoff_units = 6'd1;
    ext_en = 1'b1;
    put(1'b0, LC, LM, LC, LM, 1'b1);
    clr_state = 1'b1;
    put(1'b0, LC, LM, LC, LM, 1'b1);
    chk("R9 clear cycle no pulse", 32'(det_pulse), 0);
    clr_state = 1'b0;
    put(1'b0, LC, LM, LC, LM, 1'b1);
    chk("R9 holdoff cleared", 32'(det_pulse), 1);
    ext_en = 1'b0;
    holdoff_units = 6'd0;
    idle(20);

    // R8: statistics clear, winning over a pulse
    ext_en = 1'b1;
    clr_stats = 1'b1;
    put(1'b0, LC, LM, LC, LM, 1'b1);
    chk("R8 pulse during clear", 32'(det_pulse), 1);
    chk("R8 clear wins", det_count, 0);
    clr_stats = 1'b0;
    put(1'b0, LC, LM, LC, LM, 1'b1);
    chk("R8 count after clear", det_count, 1);
    ext_en = 1'b0;
    idle(2);

    finish_run();
  end

endmodule